// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Accumulate Unit

This block multiplies two 32-bit operands into a full 64-bit product and folds that product into a 64-bit accumulator. The accumulator is kept as a high half (the upper 32 bits) and a low half (the lower 32 bits). Four accumulating operations exist: signed add, signed subtract, unsigned add and unsigned subtract. A fifth form is a signed add whose second factor is a 16-bit immediate carried in the low half of the second operand and sign-extended. Two widening multiplies, one signed and one unsigned, replace the accumulator with the product.

Each accumulating operation writes one status flag. Signed operations write the overflow flag from the signed 64-bit add or subtract. Unsigned operations write the carry flag from the 64-bit carry out or borrow. When the flag just written is set and the exception enable input is high, the block raises a range-exception request for one cycle. Every operation takes one clock. The new accumulator, the flag-update strobes, the flag values and the exception request all appear together after the clock edge that samples the valid strobe.

Top module: `mac_unit`

## Requirements
- R1: After reset the accumulator halves, both flags, both flag-update strobes and the exception request are all zero.
- R2: Code 6 (signed widening multiply) and code 7 (unsigned widening multiply) load the 64-bit product into {acc_hi, acc_lo} without accumulating. They leave both flags unchanged and raise no update strobe and no exception.
- R3: Codes 1, 2, 5 and 6 sign-extend the operands to 64 bits before multiplying. Codes 3, 4 and 7 zero-extend them.
- R4: Code 1 adds the signed product to the accumulator. It sets ov_upd and writes ov_flag with the two's-complement overflow of the 64-bit add.
- R5: Code 2 subtracts the signed product from the accumulator. It sets ov_upd and writes ov_flag with the two's-complement overflow of the 64-bit subtract.
- R6: Code 3 adds the unsigned product to the accumulator. It sets cy_upd and writes cy_flag with the carry out of bit 63.
- R7: Code 4 subtracts the unsigned product from the accumulator. It sets cy_upd and writes cy_flag with the borrow, which is 1 exactly when the accumulator is below the product.
- R8: Code 5 multiplies op_a by op_b[15:0] sign-extended and otherwise behaves as code 1. op_b[31:16] has no effect.
- R9: range_exc is high for one cycle after an operation whose written flag is 1 while ovf_exc_en was 1. At most one of ov_upd and cy_upd is high in any cycle.
- R10: A cycle with op_valid low, or with code 0, leaves the accumulator and both flags unchanged and raises no strobe and no exception.
- R11: Results become visible one clock after op_valid is sampled, and back-to-back operations chain through the updated accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code (0 none, 1..7 as in the requirements) |
| op_a | input | 32 | First factor |
| op_b | input | 32 | Second factor; bits 15:0 are the immediate for code 5 |
| ovf_exc_en | input | 1 | Range-exception enable |
| acc_hi | output | 32 | Accumulator upper half |
| acc_lo | output | 32 | Accumulator lower half |
| ov_flag | output | 1 | Overflow flag |
| ov_upd | output | 1 | Overflow flag written in the last operation |
| cy_flag | output | 1 | Carry flag |
| cy_upd | output | 1 | Carry flag written in the last operation |
| range_exc | output | 1 | Range-exception request pulse |

## Verification
Every operation code is swept over all ordered pairs of eight corner operands: zero, one, minus one, the largest and smallest signed values, an all-ones-in-low-16 value and two mixed patterns. This separates sign extension from zero extension and add from subtract. It also shows whether the immediate path discards the upper bits of the second operand. The exception enable alternates across the sweep, so a flag that is set is seen both with and without a request. Directed sequences drive the accumulator to its signed limits and unsigned limits, where overflow, carry and borrow each appear in isolation. Idle cycles and code 0 with junk operands confirm that nothing moves.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_MAC   = 3'd1,
    OP_MSB   = 3'd2,
    OP_MACU  = 3'd3,
    OP_MSBU  = 3'd4,
    OP_MACI  = 3'd5,
    OP_MULW  = 3'd6,
    OP_MULWU = 3'd7
  } mac_op_e;

  typedef struct packed {
    logic active;   // operation changes the accumulator
    logic sgn;      // signed extension and signed flag
    logic sub;      // subtract instead of add
    logic imm;      // second factor from the immediate field
    logic widen;    // load product, no accumulation
  } mac_ctrl_t;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] code,
  output mac_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    if (valid) begin
      unique case (mac_op_e'(code))
        OP_MAC:   ctrl = '{active: 1'b1, sgn: 1'b1, sub: 1'b0, imm: 1'b0, widen: 1'b0};
        OP_MSB:   ctrl = '{active: 1'b1, sgn: 1'b1, sub: 1'b1, imm: 1'b0, widen: 1'b0};
        OP_MACU:  ctrl = '{active: 1'b1, sgn: 1'b0, sub: 1'b0, imm: 1'b0, widen: 1'b0};
        OP_MSBU:  ctrl = '{active: 1'b1, sgn: 1'b0, sub: 1'b1, imm: 1'b0, widen: 1'b0};
        OP_MACI:  ctrl = '{active: 1'b1, sgn: 1'b1, sub: 1'b0, imm: 1'b1, widen: 1'b0};
        OP_MULW:  ctrl = '{active: 1'b1, sgn: 1'b1, sub: 1'b0, imm: 1'b0, widen: 1'b1};
        OP_MULWU: ctrl = '{active: 1'b1, sgn: 1'b0, sub: 1'b0, imm: 1'b0, widen: 1'b1};
        default:  ctrl = '0;
      endcase
    end
  end

  // R8: the immediate path is only ever used with signed handling
  always_comb begin
    if (ctrl.imm) p_imm_signed_r8: assert (ctrl.sgn && !ctrl.sub && !ctrl.widen);
  end

endmodule

// File: rtl/mac_operand_prep.sv
module mac_operand_prep #(
  parameter int OPW  = 32,
  parameter int IMMW = 16,
  localparam int EXTW = 2 * OPW
) (
  input  logic [OPW-1:0]  a,
  input  logic [OPW-1:0]  b,
  input  logic            sgn,
  input  logic            imm,
  output logic [EXTW-1:0] ax,
  output logic [EXTW-1:0] bx
);

  function automatic logic [EXTW-1:0] widen_word(input logic [OPW-1:0] w, input logic s);
    logic fill;
    fill = s & w[OPW-1];
    return {{OPW{fill}}, w};
  endfunction

  function automatic logic [EXTW-1:0] widen_imm(input logic [IMMW-1:0] w);
    return {{(EXTW-IMMW){w[IMMW-1]}}, w};
  endfunction

  always_comb begin
    ax = widen_word(a, sgn);
    bx = imm ? widen_imm(b[IMMW-1:0]) : widen_word(b, sgn);
  end

  // R3: a zero-extended factor never carries bits above the operand width
  always_comb begin
    if (!sgn) p_zero_ext_r3: assert (ax[EXTW-1:OPW] == '0 && bx[EXTW-1:OPW] == '0);
  end

endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
  parameter int OPW = 32,
  localparam int EXTW = 2 * OPW
) (
  input  logic [EXTW-1:0] ax,
  input  logic [EXTW-1:0] bx,
  output logic [EXTW-1:0] prod
);

  // Both factors are already extended to the accumulator width, so the
  // truncated product is exact for signed and unsigned interpretations.
  function automatic logic [EXTW-1:0] mul_trunc(input logic [EXTW-1:0] x, input logic [EXTW-1:0] y);
    return x * y;
  endfunction

  assign prod = mul_trunc(ax, bx);

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int OPW = 32,
  localparam int ACCW = 2 * OPW
) (
  input  mac_ctrl_t       ctrl,
  input  logic [ACCW-1:0] acc,
  input  logic [ACCW-1:0] prod,
  output logic [ACCW-1:0] acc_next,
  output logic            ov_wr,
  output logic            ov_evt,
  output logic            cy_wr,
  output logic            cy_evt
);

  function automatic logic [ACCW:0] add_wide(input logic [ACCW-1:0] x, input logic [ACCW-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [ACCW:0] sub_wide(input logic [ACCW-1:0] x, input logic [ACCW-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  function automatic logic ovf_add(input logic sx, input logic sy, input logic sr);
    return (sx == sy) && (sr != sx);
  endfunction

  function automatic logic ovf_sub(input logic sx, input logic sy, input logic sr);
    return (sx != sy) && (sr != sx);
  endfunction

  logic [ACCW:0] sum_w;
  logic [ACCW:0] dif_w;
  logic          arith;

  assign sum_w = add_wide(acc, prod);
  assign dif_w = sub_wide(acc, prod);
  assign arith = ctrl.active && !ctrl.widen;

  always_comb begin
    acc_next = acc;
    ov_wr    = 1'b0;
    ov_evt   = 1'b0;
    cy_wr    = 1'b0;
    cy_evt   = 1'b0;
    if (ctrl.active && ctrl.widen) begin
      acc_next = prod;
    end else if (arith) begin
      acc_next = ctrl.sub ? dif_w[ACCW-1:0] : sum_w[ACCW-1:0];
      if (ctrl.sgn) begin
        ov_wr  = 1'b1;
        ov_evt = ctrl.sub ? ovf_sub(acc[ACCW-1], prod[ACCW-1], dif_w[ACCW-1])
                          : ovf_add(acc[ACCW-1], prod[ACCW-1], sum_w[ACCW-1]);
      end else begin
        cy_wr  = 1'b1;
        cy_evt = ctrl.sub ? dif_w[ACCW] : sum_w[ACCW];
      end
    end
  end

  // R4 R5 R6 R7: each accumulating operation writes exactly one kind of flag
  always_comb begin
    p_one_flag_kind_r6: assert (!(ov_wr && cy_wr));
    if (ov_evt) p_ov_needs_signed_r4: assert (ov_wr && ctrl.sgn);
    if (cy_evt) p_cy_needs_unsigned_r7: assert (cy_wr && !ctrl.sgn);
  end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OPW  = 32,
  parameter int IMMW = 16,
  localparam int ACCW = 2 * OPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [2:0]     op_code,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  input  logic           ovf_exc_en,
  output logic [OPW-1:0] acc_hi,
  output logic [OPW-1:0] acc_lo,
  output logic           ov_flag,
  output logic           ov_upd,
  output logic           cy_flag,
  output logic           cy_upd,
  output logic           range_exc
);

  mac_ctrl_t       ctrl;
  logic [ACCW-1:0] ax;
  logic [ACCW-1:0] bx;
  logic [ACCW-1:0] prod;
  logic [ACCW-1:0] acc_cur;
  logic [ACCW-1:0] acc_next;
  logic            ov_wr, ov_evt, cy_wr, cy_evt;
  logic            exc_evt;

  mac_decode u_decode (
    .valid (op_valid),
    .code  (op_code),
    .ctrl  (ctrl)
  );

  mac_operand_prep #(.OPW(OPW), .IMMW(IMMW)) u_prep (
    .a   (op_a),
    .b   (op_b),
    .sgn (ctrl.sgn),
    .imm (ctrl.imm),
    .ax  (ax),
    .bx  (bx)
  );

  mac_multiplier #(.OPW(OPW)) u_mul (
    .ax   (ax),
    .bx   (bx),
    .prod (prod)
  );

  assign acc_cur = {acc_hi, acc_lo};

  mac_accum #(.OPW(OPW)) u_accum (
    .ctrl     (ctrl),
    .acc      (acc_cur),
    .prod     (prod),
    .acc_next (acc_next),
    .ov_wr    (ov_wr),
    .ov_evt   (ov_evt),
    .cy_wr    (cy_wr),
    .cy_evt   (cy_evt)
  );

  assign exc_evt = ovf_exc_en && ((ov_wr && ov_evt) || (cy_wr && cy_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi    <= '0;
      acc_lo    <= '0;
      ov_flag   <= 1'b0;
      cy_flag   <= 1'b0;
      ov_upd    <= 1'b0;
      cy_upd    <= 1'b0;
      range_exc <= 1'b0;
    end else begin
      acc_hi    <= acc_next[ACCW-1:OPW];
      acc_lo    <= acc_next[OPW-1:0];
      ov_upd    <= ov_wr;
      cy_upd    <= cy_wr;
      range_exc <= exc_evt;
      if (ov_wr) ov_flag <= ov_evt;
      if (cy_wr) cy_flag <= cy_evt;
    end
  end

  // R10: an idle cycle leaves state alone and raises nothing
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_hi) && $stable(acc_lo) && $stable(ov_flag) &&
                   $stable(cy_flag) && !ov_upd && !cy_upd && !range_exc));

  // R9: only one flag kind is reported per operation
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ov_upd && cy_upd));

  // R9: an exception always comes with a written flag that is set
  p_exc_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    range_exc |-> ((ov_upd && ov_flag) || (cy_upd && cy_flag)));

  // R9: with the enable low no exception follows
  p_exc_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_exc_en |=> !range_exc);

  // R2: widening multiplies touch no flag
  p_widen_noflag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_MULW || op_code == OP_MULWU)) |=>
      (!ov_upd && !cy_upd && !range_exc && $stable(ov_flag) && $stable(cy_flag)));

endmodule

// File: tb/test_mac_unit.sv
module test_mac_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        ovf_exc_en = 1'b0;
  logic [31:0] acc_hi, acc_lo;
  logic        ov_flag, ov_upd, cy_flag, cy_upd, range_exc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  logic [63:0] m_acc = '0;
  logic        m_ov = 1'b0, m_cy = 1'b0;
  logic        e_ovu, e_cyu, e_exc;

  always #10 clk = ~clk;

  mac_unit i_mac_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .ovf_exc_en(ovf_exc_en),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .ov_flag(ov_flag), .ov_upd(ov_upd),
    .cy_flag(cy_flag), .cy_upd(cy_upd), .range_exc(range_exc)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R2";
      3'd7: return "R3";
      default: return "R10";
    endcase
  endfunction

  // Independent model of one operation
  task automatic model(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b, input bit en);
    longint      sa, sb;
    logic [63:0] p;
    logic signed [65:0] w;
    logic [65:0] u;
    e_ovu = 1'b0; e_cyu = 1'b0; e_exc = 1'b0;
    sa = longint'($signed(a));
    sb = (c == 3'd5) ? longint'($signed(b[15:0])) : longint'($signed(b));
    if (c == 3'd1 || c == 3'd2 || c == 3'd5 || c == 3'd6) p = 64'(sa * sb);
    else p = 64'(64'(a) * 64'(b));
    case (c)
      3'd1, 3'd5, 3'd2: begin
        if (c == 3'd2) w = $signed({{2{m_acc[63]}}, m_acc}) - $signed({{2{p[63]}}, p});
        else           w = $signed({{2{m_acc[63]}}, m_acc}) + $signed({{2{p[63]}}, p});
        m_ov  = (w[65:63] != 3'b000) && (w[65:63] != 3'b111);
        m_acc = w[63:0];
        e_ovu = 1'b1;
        e_exc = m_ov && en;
      end
      3'd3, 3'd4: begin
        if (c == 3'd4) begin u = {2'b0, m_acc} - {2'b0, p}; m_cy = u[65]; end
        else           begin u = {2'b0, m_acc} + {2'b0, p}; m_cy = u[64]; end
        m_acc = u[63:0];
        e_cyu = 1'b1;
        e_exc = m_cy && en;
      end
      3'd6, 3'd7: m_acc = p;
      default: ;
    endcase
  endtask

  task automatic compare(input string req);
    check({acc_hi, acc_lo} === m_acc, {req, " acc"}, {acc_hi, acc_lo}, m_acc);
    check({ov_upd, ov_flag, cy_upd, cy_flag} === {e_ovu, m_ov, e_cyu, m_cy},
          {req, " flags"}, 64'({ov_upd, ov_flag, cy_upd, cy_flag}), 64'({e_ovu, m_ov, e_cyu, m_cy}));
    check(range_exc === e_exc, {req, " R9 exc"}, 64'(range_exc), 64'(e_exc));
  endtask

  // Drive at negedge; outputs updated at the next posedge; checked at the negedge after (R11)
  task automatic do_op(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b, input bit en, input bit v);
    @(negedge clk);
    op_valid = v; op_code = c; op_a = a; op_b = b; ovf_exc_en = en;
    if (v) model(c, a, b, en);
    else begin e_ovu = 1'b0; e_cyu = 1'b0; e_exc = 1'b0; end
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd0;
    compare(v ? tag_of(c) : "R10");
  endtask

  initial begin
    logic [31:0] vals [8];
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_FFFF;
    vals[6] = 32'hDEAD_8001; vals[7] = 32'h0001_7FFF;

    repeat (3) @(negedge clk);
    // R1: reset state
    check({acc_hi, acc_lo, ov_flag, ov_upd, cy_flag, cy_upd, range_exc} === '0,
          "R1 reset", 64'({acc_hi, acc_lo}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    e_ovu = 0; e_cyu = 0; e_exc = 0;
    compare("R1");

    // R4 R9: signed overflow at the positive limit, with and without enable
    do_op(3'd6, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1);   // acc = 2^62
    check({acc_hi, acc_lo} === 64'h4000_0000_0000_0000, "R2 widen", {acc_hi, acc_lo}, 64'h4000_0000_0000_0000);
    do_op(3'd1, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1);   // 2^63 -> overflow
    check(ov_flag && range_exc, "R4 overflow exc", 64'({ov_flag, range_exc}), 64'd3);
    do_op(3'd6, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1);
    do_op(3'd1, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1);
    check(ov_flag && !range_exc, "R9 enable off", 64'({ov_flag, range_exc}), 64'd2);
    // R5: subtract overflow from the negative limit
    do_op(3'd6, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b1);
    do_op(3'd2, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1);
    do_op(3'd2, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1);
    // R6: unsigned carry
    do_op(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
    do_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
    check(cy_flag && range_exc, "R6 carry", 64'({cy_flag, range_exc}), 64'd3);
    // R7: unsigned borrow from zero, then none
    do_op(3'd7, 32'h0, 32'h0, 1'b1, 1'b1);
    do_op(3'd4, 32'h1, 32'h1, 1'b1, 1'b1);
    check({acc_hi, acc_lo} === 64'hFFFF_FFFF_FFFF_FFFF && cy_flag, "R7 borrow", {acc_hi, acc_lo}, 64'hFFFF_FFFF_FFFF_FFFF);
    do_op(3'd4, 32'h1, 32'h1, 1'b1, 1'b1);
    // R8: upper bits of op_b ignored for immediate form
    do_op(3'd7, 32'h0, 32'h0, 1'b0, 1'b1);
    do_op(3'd5, 32'h0000_0003, 32'hABCD_8000, 1'b0, 1'b1);
    check({acc_hi, acc_lo} === 64'hFFFF_FFFF_FFFE_8000, "R8 imm", {acc_hi, acc_lo}, 64'hFFFF_FFFF_FFFE_8000);
    // R10: idle and code 0 with junk
    do_op(3'd1, 32'hFFFF_FFFF, 32'h1234_5678, 1'b1, 1'b0);
    do_op(3'd0, 32'hFFFF_FFFF, 32'h1234_5678, 1'b1, 1'b1);

    // Sweep every code over all operand pairs (R3 R4 R5 R6 R7 R8 R2 R11)
    for (int c = 1; c < 8; c++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          do_op(3'(c), vals[i], vals[j], 1'((i + j) % 2), 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule